// File: doc/BRIEF.md
# Two-wire serial EEPROM target

This block is the target side of a two-wire serial memory. It works entirely in the system clock domain. The clock and data lines arrive already synchronized, and the block finds clock edges and start and stop conditions by comparing each sample with the one before. Its only bus output is a pull-low request for the data line. It is used to acknowledge, and to put read data on the wire.

The word address is 17 bits wide. The top bit travels in the device address byte, and two more bytes follow: the high address byte, then the low one. Writes collect in a one-page staging buffer. A valid stop commits them to a behavioural byte array in a self-timed cycle. While that cycle runs, the target refuses its own address, so the controller can poll for the end of the cycle. A write-protect input discards the buffer instead of committing it. Reads return bytes from the array. The address pointer advances after every byte moved, so a current-address read continues where the last access stopped.

The bus state machine has these states. IDLE waits for a start. DEV, AHI, ALO and WDATA shift in the device byte, the high address byte, the low address byte and the data bytes. DEV_ACK, AHI_ACK, ALO_ACK and WDATA_ACK hold the line low for the ninth clock. RDATA shifts a byte out. RD_ACKCHK samples the controller's answer. RD_NEXT waits for the falling edge before it loads the next byte. IGNORE waits for the next start or stop.

The transitions are as follows. A start from any state goes to DEV, and a stop from any state goes to IDLE. After eight bits, DEV goes to DEV_ACK on a match and to IGNORE on a mismatch. Each receive state goes to its ACK state, and each ACK state goes to the next receive state on the falling edge. DEV_ACK goes to RDATA when the R/W bit is set. After eight bits, RDATA goes to RD_ACKCHK. RD_ACKCHK goes to RD_NEXT when the controller acknowledges and to IGNORE when it does not. RD_NEXT goes back to RDATA.

Top module: `serial_mem_target`

## Requirements
- R1: After reset the target does not pull the data line low, no write cycle is running, and its address is acknowledged at once.
- R2: The device byte is, MSB first: the type nibble 1010, then `strap_i[1]`, then `strap_i[0]`, then the word-address MSB, then R/W (1 = read). The target acknowledges only when the nibble and both strap bits match. On a mismatch it acknowledges nothing until the next start.
- R3: A byte write is a device byte with R/W = 0, the high address byte, the low address byte, one data byte and a stop. Every byte is acknowledged, and the data lands at the address {device bit 1, high byte, low byte}.
- R4: Consecutive data bytes increment only the low 8 address bits, so a page write wraps within its 256-byte page. A later byte to the same offset overwrites the earlier one.
- R5: A read acknowledged by the controller is followed by the byte at the next address. The whole 17-bit address increments and rolls over from 0x1FFFF to 0x00000.
- R6: A random read is an address phase with R/W = 0, then a repeated start and a device byte with R/W = 1. It returns the byte at that address and commits nothing.
- R7: A read that follows a device byte with R/W = 1 and no address phase returns the byte one past the last byte read or written.
- R8: A stop that ends a write with at least one whole data byte starts a write cycle of max(WRITE_CYCLES, 256) clocks. During the cycle the device address is not acknowledged, and afterwards it is.
- R9: If `wp_i` is high at that stop, the buffer is discarded. No write cycle starts, and the array keeps its previous contents.
- R10: A stop in the middle of a data byte commits only the whole bytes before it. A start after data bytes and before a stop discards them.
- R11: When the controller does not acknowledge a read byte, the target releases the line and drives nothing until the next start or stop.
- R12: The array is indexed by the low STORE_ADDR_W bits of the 17-bit address, so addresses that agree in those bits share a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock line level |
| sda_i | input | 1 | Synchronized serial data line level |
| strap_i | input | 2 | Board strap bits the device byte must match |
| wp_i | input | 1 | Write protect; high blocks commits |
| sda_pull_o | output | 1 | 1 = pull the data line low |

## Verification
The bench sweeps every strap setting against every strap field in the device byte, so a design that compared the bits in swapped order or ignored one of them would answer the wrong address. Page writes start near the page end and run past 256 bytes. A design that carried into the page number, or that missed the overwrite, would leave data in the next page or keep stale bytes. Reads cross the 0x1FFFF boundary and then continue as current-address reads, which exposes a pointer that stops at the top, does not advance, or advances by one too many. Polling right after a stop, writes with protect high, and aborts mid-byte or by repeated start would each show up as a wrong acknowledge, a stray write cycle or a changed byte.

// File: rtl/smt_pkg.sv
package smt_pkg;

    localparam int SMT_ADDR_W = 17;
    localparam logic [3:0] SMT_DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACKCHK,
        ST_RD_NEXT,
        ST_IGNORE
    } smt_state_e;

endpackage

// File: rtl/smt_bus_events.sv
module smt_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = !scl_q && scl_i;
    assign scl_fall_o = scl_q && !scl_i;
    // data edges while the clock stays high are bus conditions
    assign start_o    = scl_q && scl_i && sda_q && !sda_i;
    assign stop_o     = scl_q && scl_i && !sda_q && sda_i;

endmodule

// File: rtl/smt_page_buffer.sv
module smt_page_buffer #(
    parameter int PAGE_LOG2 = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 wr_en_i,
    input  logic [PAGE_LOG2-1:0] wr_off_i,
    input  logic [7:0]           wr_data_i,
    input  logic [PAGE_LOG2-1:0] rd_off_i,
    output logic [7:0]           rd_data_o,
    output logic                 rd_valid_o
);
    localparam int PAGE = 1 << PAGE_LOG2;

    logic [7:0]      data_q [PAGE];
    logic [PAGE-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            data_q[wr_off_i] <= wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clr_i) begin
            valid_q <= '0;
        end else if (wr_en_i) begin
            valid_q[wr_off_i] <= 1'b1;
        end
    end

    assign rd_data_o  = data_q[rd_off_i];
    assign rd_valid_o = valid_q[rd_off_i];

endmodule

// File: rtl/smt_store.sv
module smt_store #(
    parameter int ADDR_W       = 17,
    parameter int PAGE_LOG2    = 8,
    parameter int STORE_ADDR_W = 12,
    parameter int WRITE_CYCLES = 500000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit_i,
    input  logic [ADDR_W-PAGE_LOG2-1:0] page_i,
    output logic                        busy_o,
    output logic [PAGE_LOG2-1:0]        buf_off_o,
    input  logic [7:0]                  buf_data_i,
    input  logic                        buf_valid_i,
    input  logic [ADDR_W-1:0]           rd_addr_i,
    output logic [7:0]                  rd_data_o
);
    localparam int PAGE  = 1 << PAGE_LOG2;
    localparam int TW    = (WRITE_CYCLES < PAGE) ? PAGE : WRITE_CYCLES;
    localparam int CNT_W = $clog2(TW + 1);
    localparam int DEPTH = 1 << STORE_ADDR_W;

    logic [7:0]                  mem_q [DEPTH];
    logic                        running_q;
    logic [CNT_W-1:0]            elapsed_q;
    logic [ADDR_W-PAGE_LOG2-1:0] page_q;
    logic                        copy_en;
    logic [ADDR_W-1:0]           waddr;

    assign buf_off_o = elapsed_q[PAGE_LOG2-1:0];
    assign copy_en   = running_q && (elapsed_q < CNT_W'(PAGE));
    assign waddr     = {page_q, buf_off_o};
    assign busy_o    = running_q;
    assign rd_data_o = mem_q[rd_addr_i[STORE_ADDR_W-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            elapsed_q <= '0;
            page_q    <= '0;
        end else if (commit_i && !running_q) begin
            running_q <= 1'b1;
            elapsed_q <= '0;
            page_q    <= page_i;
        end else if (running_q) begin
            if (elapsed_q == CNT_W'(TW - 1)) begin
                running_q <= 1'b0;
            end else begin
                elapsed_q <= elapsed_q + 1'b1;
            end
        end
    end

    // one staged byte per clock during the first PAGE clocks of the cycle
    always_ff @(posedge clk) begin
        if (copy_en && buf_valid_i) begin
            mem_q[waddr[STORE_ADDR_W-1:0]] <= buf_data_i;
        end
    end

    p_commit_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> !running_q);
    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && elapsed_q == CNT_W'(TW - 1)) |=> !running_q);
    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> running_q);

endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target
    import smt_pkg::*;
#(
    parameter int PAGE_LOG2    = 8,
    parameter int STORE_ADDR_W = 12,
    parameter int WRITE_CYCLES = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    input  logic       wp_i,
    output logic       sda_pull_o
);
    localparam int ADDR_W = SMT_ADDR_W;
    localparam int PAGE_W = ADDR_W - PAGE_LOG2;

    smt_state_e        state_q, state_d;
    logic [3:0]        bitcnt_q;
    logic [7:0]        rx_q, tx_q, hi_q;
    logic              rw_q, p0_q, wr_any_q;
    logic [ADDR_W-1:0] addr_q;
    logic [PAGE_W-1:0] page_q;

    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic busy, commit, buf_clr, buf_wr;
    logic byte_done, rx_state, dev_match;
    logic [7:0] rd_data, buf_rd_data;
    logic buf_rd_valid;
    logic [PAGE_LOG2-1:0] buf_off;
    logic [ADDR_W-1:0] new_addr, page_inc;

    smt_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_ev),
        .stop_o    (stop_ev)
    );

    smt_page_buffer #(.PAGE_LOG2(PAGE_LOG2)) u_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .wr_en_i   (buf_wr),
        .wr_off_i  (addr_q[PAGE_LOG2-1:0]),
        .wr_data_i (rx_q),
        .rd_off_i  (buf_off),
        .rd_data_o (buf_rd_data),
        .rd_valid_o(buf_rd_valid)
    );

    smt_store #(
        .ADDR_W      (ADDR_W),
        .PAGE_LOG2   (PAGE_LOG2),
        .STORE_ADDR_W(STORE_ADDR_W),
        .WRITE_CYCLES(WRITE_CYCLES)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit),
        .page_i     (page_q),
        .busy_o     (busy),
        .buf_off_o  (buf_off),
        .buf_data_i (buf_rd_data),
        .buf_valid_i(buf_rd_valid),
        .rd_addr_i  (addr_q),
        .rd_data_o  (rd_data)
    );

    assign byte_done = (bitcnt_q == 4'd8);
    assign rx_state  = (state_q == ST_DEV) || (state_q == ST_AHI) ||
                       (state_q == ST_ALO) || (state_q == ST_WDATA);
    assign dev_match = (rx_q[7:4] == SMT_DEV_TYPE) && (rx_q[3:2] == strap_i) && !busy;
    assign new_addr  = {p0_q, hi_q, rx_q};
    assign page_inc  = {addr_q[ADDR_W-1:PAGE_LOG2], addr_q[PAGE_LOG2-1:0] + 1'b1};
    assign buf_clr   = scl_fall && (state_q == ST_ALO) && byte_done;
    assign buf_wr    = scl_fall && (state_q == ST_WDATA) && byte_done;
    assign commit    = stop_ev && wr_any_q && !wp_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_ev) begin
            state_d = ST_DEV;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_DEV:       if (scl_fall && byte_done) state_d = dev_match ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK:   if (scl_fall) state_d = rw_q ? ST_RDATA : ST_AHI;
                ST_AHI:       if (scl_fall && byte_done) state_d = ST_AHI_ACK;
                ST_AHI_ACK:   if (scl_fall) state_d = ST_ALO;
                ST_ALO:       if (scl_fall && byte_done) state_d = ST_ALO_ACK;
                ST_ALO_ACK:   if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && byte_done) state_d = ST_RD_ACKCHK;
                ST_RD_ACKCHK: if (scl_rise) state_d = sda_i ? ST_IGNORE : ST_RD_NEXT;
                ST_RD_NEXT:   if (scl_fall) state_d = ST_RDATA;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            rx_q     <= '0;
            tx_q     <= '0;
            hi_q     <= '0;
            rw_q     <= 1'b0;
            p0_q     <= 1'b0;
            wr_any_q <= 1'b0;
            addr_q   <= '0;
            page_q   <= '0;
        end else if (start_ev || stop_ev) begin
            bitcnt_q <= '0;
            wr_any_q <= 1'b0;
        end else begin
            if (scl_rise && rx_state && !byte_done) begin
                rx_q     <= {rx_q[6:0], sda_i};
                bitcnt_q <= bitcnt_q + 1'b1;
            end
            if (scl_rise && (state_q == ST_RDATA) && !byte_done) begin
                bitcnt_q <= bitcnt_q + 1'b1;
            end
            if (scl_fall) begin
                case (state_q)
                    ST_DEV: if (byte_done && dev_match) begin
                        rw_q <= rx_q[0];
                        p0_q <= rx_q[1];
                    end
                    ST_DEV_ACK: begin
                        bitcnt_q <= '0;
                        if (rw_q) begin
                            tx_q   <= rd_data;
                            addr_q <= addr_q + 1'b1;
                        end
                    end
                    ST_AHI: if (byte_done) hi_q <= rx_q;
                    ST_ALO: if (byte_done) begin
                        addr_q <= new_addr;
                        page_q <= new_addr[ADDR_W-1:PAGE_LOG2];
                    end
                    ST_WDATA: if (byte_done) begin
                        addr_q   <= page_inc;
                        wr_any_q <= 1'b1;
                    end
                    ST_AHI_ACK, ST_ALO_ACK, ST_WDATA_ACK: bitcnt_q <= '0;
                    ST_RDATA: if (!byte_done) tx_q <= {tx_q[6:0], 1'b0};
                    ST_RD_NEXT: begin
                        bitcnt_q <= '0;
                        tx_q     <= rd_data;
                        addr_q   <= addr_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_pull_o = 1'b0;
        unique case (state_q)
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDATA_ACK: sda_pull_o = 1'b1;
            ST_RDATA: sda_pull_o = !tx_q[7];
            default:  sda_pull_o = 1'b0;
        endcase
    end

    p_no_ack_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV_ACK) |-> !busy);
    p_wp_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ev && wp_i && !busy) |=> !busy);
    p_page_confined_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDATA_ACK) |-> (addr_q[ADDR_W-1:PAGE_LOG2] == page_q));
    p_release_nack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_ACKCHK && scl_rise && sda_i) |=> !sda_pull_o);
    p_bad_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV && scl_fall && byte_done && rx_q[7:4] != SMT_DEV_TYPE)
        |=> (state_q == ST_IGNORE));

endmodule

// File: tb/serial_mem_target_tb.sv
module serial_mem_target_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WC         = 300;
    localparam int SAW        = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic [1:0] strap = 2'b10;
    logic       sda_pull;
    wire        sda_line = sda_m & ~sda_pull;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [1 << SAW];

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_mem_target #(
        .PAGE_LOG2   (8),
        .STORE_ADDR_W(SAW),
        .WRITE_CYCLES(WC)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .strap_i   (strap),
        .wp_i      (wp),
        .sda_pull_o(sda_pull)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(2);
        scl_m = 1'b1; tick(3);
        sda_m = 1'b0; tick(3);
        scl_m = 1'b0; tick(3);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(2);
        scl_m = 1'b1; tick(3);
        sda_m = 1'b1; tick(3);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i >= 8 - n; i--) begin
            sda_m = b[i]; tick(2);
            scl_m = 1'b1; tick(3);
            scl_m = 1'b0; tick(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(2);
        scl_m = 1'b1; tick(1);
        ack = !sda_line; tick(2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(2);
            scl_m = 1'b1; tick(1);
            b[i] = sda_line; tick(2);
            scl_m = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; tick(2);
        scl_m = 1'b1; tick(3);
        scl_m = 1'b0; tick(1);
        sda_m = 1'b1; tick(1);
    endtask

    function automatic logic [7:0] devb(input bit p0, input bit rd);
        return {4'b1010, strap, p0, rd};
    endfunction

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 7 + i * 13 + 5) & 255);
    endfunction

    task automatic addr_phase(input int addr, output bit ok);
        bit a0, a1, a2;
        bus_start();
        send_byte(devb(addr[16], 1'b0), a0);
        send_byte(8'(addr >> 8), a1);
        send_byte(8'(addr), a2);
        ok = a0 & a1 & a2;
    endtask

    task automatic poll(output bit ack);
        bus_start();
        send_byte(devb(1'b0, 1'b0), ack);
        bus_stop();
    endtask

    task automatic write_seq(input int addr, input int n, input int seed,
                             input bit upd, input bit wait_done);
        bit ok, a;
        int all;
        addr_phase(addr, ok);
        all = ok;
        for (int i = 0; i < n; i++) begin
            int wa;
            send_byte(pat(seed, i), a);
            all = all & a;
            wa = (addr & 32'h1FF00) | ((addr + i) & 32'hFF);
            if (upd) model[wa % (1 << SAW)] = pat(seed, i);
        end
        bus_stop();
        check("R3", "write sequence acknowledged", all, 1);
        if (wait_done) tick(WC + 20);
    endtask

    task automatic read_seq(input int addr, input int n, input string req);
        bit ok, a;
        logic [7:0] b;
        addr_phase(addr, ok);
        bus_start();
        send_byte(devb(1'b0, 1'b1), a);
        check(req, "read address phase acked", int'(ok & a), 1);
        for (int i = 0; i < n; i++) begin
            int ra;
            recv_byte(i != n - 1, b);
            ra = ((addr + i) & 32'h1FFFF) % (1 << SAW);
            check(req, $sformatf("read byte %0d of %0h", i, addr), b, model[ra]);
        end
        bus_stop();
    endtask

    task automatic cur_read(input int exp_addr, input string req);
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(devb(1'b0, 1'b1), a);
        recv_byte(1'b0, b);
        bus_stop();
        check(req, "current address read", b, model[exp_addr % (1 << SAW)]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] b;
        tick(5);
        rst_n = 1'b1;
        tick(3);

        // R1: reset state
        check("R1", "line released after reset", sda_pull, 0);
        poll(ack);
        check("R1", "address acked after reset", ack, 1);

        // R2: strap sweep
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 4; a++) begin
                strap = 2'(s);
                bus_start();
                send_byte({4'b1010, 2'(a), 2'b00}, ack);
                bus_stop();
                check("R2", $sformatf("strap %0d field %0d", s, a), ack, int'(a == s));
            end
        end
        strap = 2'b10;
        bus_start();
        send_byte({4'b1011, strap, 2'b00}, ack);
        check("R2", "wrong type nibble", ack, 0);
        send_byte(8'h00, ack);
        check("R2", "bytes after mismatch", ack, 0);
        bus_stop();

        // R3, R6, R12: byte write with top address bit
        write_seq(32'h12345, 1, 1, 1'b1, 1'b1);
        read_seq(32'h12345, 1, "R6");
        read_seq(32'h00345, 1, "R12");

        // R8: busy polling
        write_seq(32'h00800, 1, 2, 1'b1, 1'b0);
        poll(ack);
        check("R8", "address refused during write cycle", ack, 0);
        tick(WC + 20);
        poll(ack);
        check("R8", "address acked after write cycle", ack, 1);
        read_seq(32'h00800, 1, "R8");

        // R4: wrap within page, and overrun past 256
        write_seq(32'h003F0, 32, 3, 1'b1, 1'b1);
        read_seq(32'h003F0, 16, "R4");
        read_seq(32'h00300, 16, "R4");
        write_seq(32'h00600, 258, 9, 1'b1, 1'b1);
        read_seq(32'h00600, 256, "R4");

        // R5, R7, R11: full address rollover and current read
        write_seq(32'h1FFFF, 1, 4, 1'b1, 1'b1);
        write_seq(32'h00000, 1, 5, 1'b1, 1'b1);
        write_seq(32'h00001, 1, 6, 1'b1, 1'b1);
        read_seq(32'h1FFFF, 2, "R5");
        cur_read(32'h00001, "R7");
        write_seq(32'h00778, 1, 7, 1'b1, 1'b1);
        write_seq(32'h00777, 1, 8, 1'b1, 1'b1);
        cur_read(32'h00778, "R7");
        bus_start();
        send_byte(devb(1'b0, 1'b1), ack);
        recv_byte(1'b0, b);
        recv_byte(1'b0, b);
        check("R11", "no drive after controller nack", b, 8'hFF);
        bus_stop();

        // R9: write protect
        write_seq(32'h00900, 1, 10, 1'b1, 1'b1);
        wp = 1'b1;
        write_seq(32'h00900, 1, 11, 1'b0, 1'b0);
        poll(ack);
        check("R9", "no write cycle under protect", ack, 1);
        wp = 1'b0;
        read_seq(32'h00900, 1, "R9");

        // R10: aborts
        write_seq(32'h00501, 1, 12, 1'b1, 1'b1);
        addr_phase(32'h00500, ack);
        send_byte(8'h11, ack);
        send_bits(8'hF0, 4);
        bus_stop();
        model[12'h500] = 8'h11;
        tick(WC + 20);
        read_seq(32'h00500, 2, "R10");
        addr_phase(32'h00500, ack);
        send_byte(8'h33, ack);
        bus_start();
        bus_stop();
        poll(ack);
        check("R10", "repeated start discards buffer", ack, 1);
        read_seq(32'h00500, 1, "R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule